// File: doc/BRIEF.md
# Half-Bridge Gate Oscillator with Dead-Time and Ignition Ramp

This block produces the two gate commands of a half-bridge. The low-side and high-side commands turn on in alternation. Each on-time is followed by a programmable dead-time, during which both commands are off. The on-time, counted in clock cycles, comes from one of three sources, chosen by a mode input:

- a preheat count, which is short and gives a high switching rate;
- a run count, which is long and gives a lower switching rate;
- an internal ramp, used during ignition.

In ignition the ramp starts at the preheat count and rises by a fixed step every N half-cycles until it reaches the run count. At that point a done flag goes high, and the controller can move to run mode.

After enable, the low side always switches first, so that the floating high-side supply is charged before the first high-side pulse. Dropping the enable turns both commands off in the same cycle and returns all timing state to idle. On-time values are taken only when a new on-time starts, so a count that changes mid-pulse never shortens or stretches a pulse already in progress. A strobe output marks every low-side on-time, so that external current-sense logic can qualify its events.

Top module: `hb_osc`

## Requirements
- R1: Out of reset, and while disabled, `ho_o`, `lo_o`, `lo_strobe_o` and `ramp_done_o` are all 0.
- R2: After `en_i` is sampled high at a clock edge while idle, `lo_o` is high from that edge on, and the first on-time after every enable is on the low side.
- R3: On-times alternate low, high, low, ... and each lasts exactly the selected on-time count in clock cycles; a count of 0 behaves as 1. The two outputs are never high together.
- R4: Between consecutive on-times, both outputs are low for exactly `dead_cnt_i` cycles; a count of 0 behaves as 1.
- R5: Mode encoding of `mode_i`: 0 selects `ph_cnt_i`, 1 selects the ignition ramp, and 2 or 3 selects `run_cnt_i`.
- R6: In ignition the ramp value starts at `ph_cnt_i`. At the start of every `ramp_div_i`-th on-time it grows by `ramp_step_i`, and it is clipped at `run_cnt_i`; a `ramp_div_i` of 0 behaves as 1. The on-time that starts at the same edge as an update still uses the value from before the update.
- R7: `ramp_done_o` is high only in ignition mode, from the cycle after the ramp value reaches `run_cnt_i`. Once high, it stays high while the mode, the run count and the enable are unchanged.
- R8: On-time counts are taken only at the start of each on-time; a change during a pulse has no effect on that pulse's width.
- R9: Driving `en_i` low forces both outputs low in the same cycle, without waiting for a clock edge.
- R10: `lo_strobe_o` is high in exactly the cycles in which `lo_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Oscillator enable |
| mode_i | input | 2 | 0 preheat, 1 ignition, 2/3 run |
| ph_cnt_i | input | CNT_W | Preheat on-time in cycles |
| run_cnt_i | input | CNT_W | Run on-time in cycles |
| dead_cnt_i | input | CNT_W | Dead-time in cycles |
| ramp_step_i | input | STEP_W | Ramp increment per update |
| ramp_div_i | input | DIV_W | Half-cycles between ramp updates |
| ho_o | output | 1 | High-side gate command |
| lo_o | output | 1 | Low-side gate command |
| lo_strobe_o | output | 1 | High during each low-side on-time |
| ramp_done_o | output | 1 | Ignition ramp has reached the run count |

## Verification
The bench builds the block with CNT_W=8, STEP_W=4 and DIV_W=3, so pulses last only a few cycles. These settings make a full ignition ramp observable within a handful of pulses:

- Preheat 4, run 10, step 4 and divider 2 reach the clipped final step, from 8 to 10, in the fifth pulse.
- A divider of 0 with step 3 shows an update at every half-cycle.

The small counts also make the zero-count dead-time case, the mid-pulse count change and the mid-pulse disable cheap to reach.

// File: rtl/hb_osc_pkg.sv
package hb_osc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_LO_ON   = 3'd1,
    PH_LO_DEAD = 3'd2,
    PH_HI_ON   = 3'd3,
    PH_HI_DEAD = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    MODE_PREHEAT = 2'd0,
    MODE_IGNITE  = 2'd1,
    MODE_RUN     = 2'd2,
    MODE_RUN_ALT = 2'd3
  } mode_e;
endpackage

// File: rtl/hb_phase_seq.sv
module hb_phase_seq
  import hb_osc_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] on_cnt_i,
  input  logic [CNT_W-1:0] dead_cnt_i,
  output phase_e           phase_o,
  output logic             hc_start_o
);
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero;

  // a zero count still yields one cycle
  function automatic logic [CNT_W-1:0] load_val(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    hc_start_o = 1'b0;
    if (en_i) begin
      unique case (phase_q)
        PH_IDLE:                hc_start_o = 1'b1;
        PH_LO_DEAD, PH_HI_DEAD: hc_start_o = cnt_zero;
        default:                hc_start_o = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (!en_i) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_q <= PH_LO_ON;
          cnt_q   <= load_val(on_cnt_i);
        end
        PH_LO_ON: begin
          if (cnt_zero) begin
            phase_q <= PH_LO_DEAD;
            cnt_q   <= load_val(dead_cnt_i);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_LO_DEAD: begin
          if (cnt_zero) begin
            phase_q <= PH_HI_ON;
            cnt_q   <= load_val(on_cnt_i);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_HI_ON: begin
          if (cnt_zero) begin
            phase_q <= PH_HI_DEAD;
            cnt_q   <= load_val(dead_cnt_i);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_HI_DEAD: begin
          if (cnt_zero) begin
            phase_q <= PH_LO_ON;
            cnt_q   <= load_val(on_cnt_i);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/hb_ramp.sv
module hb_ramp #(
  parameter int CNT_W  = 12,
  parameter int STEP_W = 8,
  parameter int DIV_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ign_i,
  input  logic              hc_start_i,
  input  logic [CNT_W-1:0]  ph_cnt_i,
  input  logic [CNT_W-1:0]  run_cnt_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic [CNT_W-1:0]  ramp_o,
  output logic              done_o
);
  localparam int SUM_W = CNT_W + 1;
  localparam int PAD_W = SUM_W - STEP_W;

  logic [CNT_W-1:0] ramp_q;
  logic [DIV_W-1:0] hc_q;
  logic [DIV_W:0]   hc_inc;
  logic [SUM_W-1:0] sum;
  logic [CNT_W-1:0] ramp_nxt;
  logic             upd;

  assign hc_inc = {1'b0, hc_q} + 1'b1;
  assign upd    = (hc_inc >= {1'b0, div_i});
  assign sum    = {1'b0, ramp_q} + {{PAD_W{1'b0}}, step_i};

  always_comb begin
    if (ramp_q >= run_cnt_i || sum >= {1'b0, run_cnt_i}) ramp_nxt = run_cnt_i;
    else                                                    ramp_nxt = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ramp_q <= '0;
      hc_q   <= '0;
    end else if (!en_i || !ign_i) begin
      ramp_q <= ph_cnt_i;
      hc_q   <= '0;
    end else if (hc_start_i) begin
      if (upd) begin
        hc_q   <= '0;
        ramp_q <= ramp_nxt;
      end else begin
        hc_q <= hc_inc[DIV_W-1:0];
      end
    end
  end

  assign ramp_o = ramp_q;
  assign done_o = en_i && ign_i && (ramp_q == run_cnt_i);
endmodule

// File: rtl/hb_ontime_sel.sv
module hb_ontime_sel
  import hb_osc_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] ph_cnt_i,
  input  logic [CNT_W-1:0] run_cnt_i,
  input  logic [CNT_W-1:0] ramp_i,
  output logic [CNT_W-1:0] on_cnt_o
);
  always_comb begin
    unique case (mode_e'(mode_i))
      MODE_PREHEAT: on_cnt_o = ph_cnt_i;
      MODE_IGNITE:  on_cnt_o = ramp_i;
      default:      on_cnt_o = run_cnt_i;
    endcase
  end
endmodule

// File: rtl/hb_osc.sv
module hb_osc
  import hb_osc_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int STEP_W = 8,
  parameter int DIV_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [1:0]        mode_i,
  input  logic [CNT_W-1:0]  ph_cnt_i,
  input  logic [CNT_W-1:0]  run_cnt_i,
  input  logic [CNT_W-1:0]  dead_cnt_i,
  input  logic [STEP_W-1:0] ramp_step_i,
  input  logic [DIV_W-1:0]  ramp_div_i,
  output logic              ho_o,
  output logic              lo_o,
  output logic              lo_strobe_o,
  output logic              ramp_done_o
);
  phase_e           phase;
  logic             hc_start;
  logic [CNT_W-1:0] on_cnt;
  logic [CNT_W-1:0] ramp_val;
  logic             ign;

  assign ign = (mode_e'(mode_i) == MODE_IGNITE);

  hb_ontime_sel #(.CNT_W(CNT_W)) u_sel (
    .mode_i    (mode_i),
    .ph_cnt_i  (ph_cnt_i),
    .run_cnt_i (run_cnt_i),
    .ramp_i    (ramp_val),
    .on_cnt_o  (on_cnt)
  );

  hb_ramp #(.CNT_W(CNT_W), .STEP_W(STEP_W), .DIV_W(DIV_W)) u_ramp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .ign_i      (ign),
    .hc_start_i (hc_start),
    .ph_cnt_i   (ph_cnt_i),
    .run_cnt_i  (run_cnt_i),
    .step_i     (ramp_step_i),
    .div_i      (ramp_div_i),
    .ramp_o     (ramp_val),
    .done_o     (ramp_done_o)
  );

  hb_phase_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .on_cnt_i   (on_cnt),
    .dead_cnt_i (dead_cnt_i),
    .phase_o    (phase),
    .hc_start_o (hc_start)
  );

  // enable gates the outputs combinationally: off without waiting for an edge
  assign lo_o        = en_i && (phase == PH_LO_ON);
  assign ho_o        = en_i && (phase == PH_HI_ON);
  assign lo_strobe_o = lo_o;
endmodule

// File: rtl/hb_osc_chk.sv
module hb_osc_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [1:0]       mode_i,
  input logic [CNT_W-1:0] run_cnt_i,
  input logic             ho_o,
  input logic             lo_o,
  input logic             ramp_done_o
);
  logic seen_lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seen_lo_q <= 1'b0;
    else if (!en_i)  seen_lo_q <= 1'b0;
    else if (lo_o)   seen_lo_q <= 1'b1;
  end

  a_r3_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ho_o && lo_o));

  a_r4_lo_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_o |=> !ho_o);

  a_r4_hi_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ho_o |=> !lo_o);

  a_r2_lo_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ho_o) |-> seen_lo_q);

  a_r7_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_done_o && en_i && mode_i == 2'd1) |=>
      (ramp_done_o || !en_i || mode_i != 2'd1 || !$stable(run_cnt_i)));

  a_r7_done_only_ign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_done_o |-> (mode_i == 2'd1));
endmodule

bind hb_osc hb_osc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .mode_i      (mode_i),
  .run_cnt_i   (run_cnt_i),
  .ho_o        (ho_o),
  .lo_o        (lo_o),
  .ramp_done_o (ramp_done_o)
);

// File: tb/tb_hb_osc.sv
module tb_hb_osc;
  localparam int CLK_P  = 10;
  localparam int CNT_W  = 8;
  localparam int STEP_W = 4;
  localparam int DIV_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b0;
  logic [1:0]        mode = 2'd0;
  logic [CNT_W-1:0]  ph_cnt = '0;
  logic [CNT_W-1:0]  run_cnt = '0;
  logic [CNT_W-1:0]  dead_cnt = '0;
  logic [STEP_W-1:0] step = '0;
  logic [DIV_W-1:0]  div = '0;
  logic              ho, lo, strobe, done;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  hb_osc #(.CNT_W(CNT_W), .STEP_W(STEP_W), .DIV_W(DIV_W)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .mode_i      (mode),
    .ph_cnt_i    (ph_cnt),
    .run_cnt_i   (run_cnt),
    .dead_cnt_i  (dead_cnt),
    .ramp_step_i (step),
    .ramp_div_i  (div),
    .ho_o        (ho),
    .lo_o        (lo),
    .lo_strobe_o (strobe),
    .ramp_done_o (done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the first negedge after the pulse
  task automatic get_pulse(output int side, output int w, output int done_at_start);
    int t = 0;
    while (!(ho || lo) && t < 2000) begin
      @(negedge clk);
      t++;
    end
    side = ho ? 1 : 0;
    done_at_start = int'(done);
    w = 0;
    while ((side == 1) ? ho : lo) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic get_gap(output int g);
    g = 0;
    while (!(ho || lo) && g < 2000) begin
      g++;
      @(negedge clk);
    end
  endtask

  task automatic disable_osc();
    @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ho after reset", int'(ho), 0);
    chk("R1 lo after reset", int'(lo), 0);
    chk("R1 done after reset", int'(done), 0);
    chk("R10 strobe after reset", int'(strobe), 0);
  endtask

  task automatic t_first_lo();
    int s, w, d, g;
    mode = 2'd0; ph_cnt = 8'd5; dead_cnt = 8'd3; run_cnt = 8'd9;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    chk("R2 lo one edge after enable", int'(lo), 1);
    get_pulse(s, w, d);
    chk("R2 first side low", s, 0);
    chk("R3 preheat low width", w, 5);
    get_gap(g);
    chk("R4 dead width", g, 3);
    get_pulse(s, w, d);
    chk("R3 second side high", s, 1);
    chk("R3 preheat high width", w, 5);
    get_gap(g);
    chk("R4 dead width after high", g, 3);
    get_pulse(s, w, d);
    chk("R3 third side low", s, 0);
  endtask

  task automatic t_run_dead0();
    int s, w, d, g;
    disable_osc();
    mode = 2'd2; run_cnt = 8'd9; dead_cnt = 8'd0;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    get_pulse(s, w, d);
    chk("R5 run low width", w, 9);
    get_gap(g);
    chk("R4 zero dead acts as one", g, 1);
    get_pulse(s, w, d);
    chk("R5 run high side", s, 1);
    chk("R5 run high width", w, 9);
    mode = 2'd3;
    get_gap(g);
    get_pulse(s, w, d);
    chk("R5 mode 3 uses run count", w, 9);
  endtask

  task automatic t_zero_on();
    int s, w, d, g;
    disable_osc();
    mode = 2'd0; ph_cnt = 8'd0; dead_cnt = 8'd2;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    get_pulse(s, w, d);
    chk("R3 zero on-count acts as one", w, 1);
    get_gap(g);
    chk("R4 dead after one-cycle pulse", g, 2);
  endtask

  task automatic t_disable();
    int s, w, d;
    disable_osc();
    mode = 2'd2; run_cnt = 8'd8; dead_cnt = 8'd2;
    @(negedge clk);
    en = 1'b1;
    while (!ho) @(negedge clk);
    @(negedge clk);
    en = 1'b0;
    #1;
    chk("R9 ho low at once", int'(ho), 0);
    chk("R9 lo low at once", int'(lo), 0);
    @(negedge clk);
    chk("R1 ho stays low disabled", int'(ho), 0);
    chk("R1 lo stays low disabled", int'(lo), 0);
    en = 1'b1;
    @(negedge clk);
    get_pulse(s, w, d);
    chk("R2 restart on low side", s, 0);
    chk("R2 restart full width", w, 8);
  endtask

  task automatic t_boundary();
    int s, w, d, g;
    disable_osc();
    mode = 2'd0; ph_cnt = 8'd6; dead_cnt = 8'd1;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    w = 0;
    while (lo) begin
      w++;
      if (w == 2) ph_cnt = 8'd3;
      @(negedge clk);
    end
    chk("R8 pulse in flight keeps width", w, 6);
    get_gap(g);
    get_pulse(s, w, d);
    chk("R8 next pulse takes new count", w, 3);
  endtask

  task automatic t_ignite();
    int s, w, d;
    int exp_w[6] = '{4, 4, 8, 8, 10, 10};
    int exp_d[6] = '{0, 0, 0, 1, 1, 1};
    disable_osc();
    mode = 2'd1; ph_cnt = 8'd4; run_cnt = 8'd10; step = 4'd4; div = 3'd2; dead_cnt = 8'd1;
    @(negedge clk);
    chk("R7 done low while disabled", int'(done), 0);
    en = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      get_pulse(s, w, d);
      chk($sformatf("R6 ramp pulse %0d width", i), w, exp_w[i]);
      chk($sformatf("R3 ramp pulse %0d side", i), s, i % 2);
      chk($sformatf("R7 done at pulse %0d", i), d, exp_d[i]);
    end
    mode = 2'd2;
    #1;
    chk("R7 done low outside ignition", int'(done), 0);
  endtask

  task automatic t_div0();
    int s, w, d;
    int exp_w[4] = '{2, 5, 8, 11};
    disable_osc();
    mode = 2'd1; ph_cnt = 8'd2; run_cnt = 8'd20; step = 4'd3; div = 3'd0; dead_cnt = 8'd1;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      get_pulse(s, w, d);
      chk($sformatf("R6 div zero pulse %0d", i), w, exp_w[i]);
    end
  endtask

  task automatic t_strobe();
    int bad = 0;
    int hits = 0;
    disable_osc();
    mode = 2'd2; run_cnt = 8'd4; dead_cnt = 8'd2;
    @(negedge clk);
    en = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (strobe != lo) bad++;
      if (strobe) hits++;
    end
    chk("R10 strobe equals lo", bad, 0);
    chk("R10 strobe active cycles", hits, 20);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first_lo();
    t_run_dead0();
    t_zero_on();
    t_disable();
    t_boundary();
    t_ignite();
    t_div0();
    t_strobe();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule